// File: doc/BRIEF.md
# Recirculating Serial Shift Register with Half-Stage Tap

A long serial delay line built from full edge-triggered stages. On every rising clock edge one bit enters the first stage and every stage takes the value of the stage in front of it. After a parameterised number of rising edges (64 by default) the bit appears on the true output, and its inverse appears on a complement output.

The bit that enters the first stage comes from one of two sources. A source-select input picks either the external data input or a recirculation input. The recirculation input is normally tied back to the register's own output, so the stored word circulates without change.

An extra half stage copies the final stage on the falling clock edge that follows each update. This gives a tap that lags the true output by half a clock period, so a following unit that uses slow clock edges can take data from it safely. A clock-forwarding output repeats the clock so that a chain of units can be clocked in series. A synchronous clear input empties the register for test use.

Top module: `recirc_shift_reg`

## Requirements
- R1: When `clear` is high at a rising edge, every full stage becomes 0, so `q_out` is 0 right after that edge. When `clear` is high at a falling edge, `q_half` becomes 0.
- R2: With `clear` low, the value on `q_out` after a rising edge is the bit that entered the first stage exactly NUM_STAGES rising edges earlier (64 by default).
- R3: When `src_sel` is 0 at a rising edge, the bit that enters stage 1 is `data_in`, and `recirc_in` has no effect.
- R4: When `src_sel` is 1 at a rising edge, the bit that enters stage 1 is `recirc_in`, and `data_in` has no effect.
- R5: `q_out_n` is always the inverse of `q_out`.
- R6: After each falling edge, `q_half` equals the value `q_out` took at the rising edge before it.
- R7: `q_half` does not change on rising edges, and the full stages do not change on falling edges.
- R8: If the clock stops, whether it rests high or low, the stored contents and the outputs stay as they were. Shifting then resumes without loss.
- R9: `clk_fwd` follows `clk` at all times.
- R10: With `src_sel` at 1 and `recirc_in` fed from `q_out`, the stored word circulates: `q_out` repeats with a period of NUM_STAGES rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; full stages capture on the rising edge, the half stage on the falling edge |
| clear | input | 1 | Synchronous active-high clear of all stages (test use) |
| src_sel | input | 1 | Source select for stage 1: 0 selects data_in, 1 selects recirc_in |
| data_in | input | 1 | External serial data |
| recirc_in | input | 1 | Recirculation data, normally tied to q_out |
| q_out | output | 1 | Final full stage |
| q_out_n | output | 1 | Inverse of q_out |
| q_half | output | 1 | Half-stage copy of q_out, updated on falling edges |
| clk_fwd | output | 1 | Forwarded clock for cascaded units |

## Verification
The bench measures the full-length latency by sending a single 1 through a cleared register and counting edges. An off-by-one stage count would show the 1 one edge early or late. It runs both source modes while driving the input that is not selected with the opposite pattern. An inverted or swapped select would then pass the wrong pattern to the output. The half-stage tap is sampled just after both clock edges. A design that updates it on the rising edge, or that copies the stage before the last, shows the new bit half a period too early. The bench also stops the clock in each of its two levels and closes the recirculation loop for two full rotations. A design that loses state while the clock is parked, or that drops or repeats a bit around the loop, then breaks the expected sequence.

// File: rtl/srl_pkg.sv
package srl_pkg;

    // Source for the bit that enters the first stage
    typedef enum logic {
        SRC_DATA   = 1'b0,
        SRC_RECIRC = 1'b1
    } src_sel_e;

endpackage

// File: rtl/srl_input_mux.sv
module srl_input_mux
    import srl_pkg::*;
(
    input  logic sel_i,
    input  logic data_i,
    input  logic recirc_i,
    output logic bit_o
);

    src_sel_e sel_e;

    always_comb begin
        sel_e = src_sel_e'(sel_i);
        unique case (sel_e)
            SRC_RECIRC: bit_o = recirc_i;
            default:    bit_o = data_i;
        endcase
    end

endmodule

// File: rtl/srl_stage_chain.sv
module srl_stage_chain #(
    parameter int NUM_STAGES = 64
) (
    input  logic clk,
    input  logic clear,
    input  logic bit_i,
    output logic first_o,
    output logic last_o
);

    localparam int LAST = NUM_STAGES - 1;

    typedef struct packed {
        logic [LAST:0] stages;
    } chain_t;

    chain_t chain_d, chain_q;

    generate
        if (NUM_STAGES == 1) begin : g_single
            always_comb begin
                chain_d = chain_q;
                chain_d.stages[0] = clear ? 1'b0 : bit_i;
            end
        end else begin : g_multi
            always_comb begin
                chain_d = chain_q;
                if (clear) begin
                    chain_d.stages = '0;
                end else begin
                    chain_d.stages = {chain_q.stages[LAST-1:0], bit_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign first_o = chain_q.stages[0];
    assign last_o  = chain_q.stages[LAST];

    // The cycle after clear falls, the output stage must be empty
    assert_clear_empties_R1: assert property (@(posedge clk) disable iff (clear)
        $fell(clear) |-> (last_o == 1'b0));

endmodule

// File: rtl/srl_half_stage.sv
module srl_half_stage (
    input  logic clk,
    input  logic clear,
    input  logic d_i,
    output logic q_o
);

    typedef struct packed {
        logic bit_v;
    } half_t;

    half_t half_d, half_q;

    always_comb begin
        half_d = half_q;
        half_d.bit_v = clear ? 1'b0 : d_i;
    end

    always_ff @(negedge clk) begin
        half_q <= half_d;
    end

    assign q_o = half_q.bit_v;

    // At every rising edge the half stage holds what the last stage held
    // through the preceding low phase
    assert_half_tracks_R6: assert property (@(posedge clk) disable iff (clear)
        q_o == d_i);

endmodule

// File: rtl/recirc_shift_reg.sv
module recirc_shift_reg #(
    parameter int NUM_STAGES = 64
) (
    input  logic clk,
    input  logic clear,
    input  logic src_sel,
    input  logic data_in,
    input  logic recirc_in,
    output logic q_out,
    output logic q_out_n,
    output logic q_half,
    output logic clk_fwd
);

    logic entry_bit;
    logic first_stage;
    logic last_stage;

    srl_input_mux i_mux (
        .sel_i    (src_sel),
        .data_i   (data_in),
        .recirc_i (recirc_in),
        .bit_o    (entry_bit)
    );

    srl_stage_chain #(.NUM_STAGES(NUM_STAGES)) i_chain (
        .clk     (clk),
        .clear   (clear),
        .bit_i   (entry_bit),
        .first_o (first_stage),
        .last_o  (last_stage)
    );

    srl_half_stage i_half (
        .clk   (clk),
        .clear (clear),
        .d_i   (last_stage),
        .q_o   (q_half)
    );

    assign q_out   = last_stage;
    assign q_out_n = ~last_stage;
    assign clk_fwd = clk;

    // Data mode loads data_in into stage 1
    assert_data_mode_R3: assert property (@(posedge clk) disable iff (clear)
        (!$past(clear) && !$past(src_sel)) |-> (first_stage == $past(data_in)));

    // Recirculation mode loads recirc_in into stage 1
    assert_recirc_mode_R4: assert property (@(posedge clk) disable iff (clear)
        (!$past(clear) && $past(src_sel)) |-> (first_stage == $past(recirc_in)));

endmodule

// File: tb/test_recirc_shift_reg.sv
module test_recirc_shift_reg;

    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    logic clk = 1'b0;
    logic clk_run = 1'b1;
    logic clear = 1'b1;
    logic src_sel = 1'b0;
    logic data_in = 1'b0;
    logic recirc_in = 1'b0;
    logic q_out, q_out_n, q_half, clk_fwd;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [N-1:0] model = '0;

    recirc_shift_reg #(.NUM_STAGES(N)) i_recirc_shift_reg (
        .clk       (clk),
        .clear     (clear),
        .src_sel   (src_sel),
        .data_in   (data_in),
        .recirc_in (recirc_in),
        .q_out     (q_out),
        .q_out_n   (q_out_n),
        .q_half    (q_half),
        .clk_fwd   (clk_fwd)
    );

    always begin
        #(CLK_PERIOD/2);
        if (clk_run) clk = ~clk;
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One shift: drive, rising edge, checks, falling edge, checks
    task automatic tick(input logic d, input logic s, input logic r);
        logic prev;
        data_in = d; src_sel = s; recirc_in = r;
        prev = model[N-1];
        @(posedge clk);
        if (clear) model = '0;
        else       model = {model[N-2:0], (s ? r : d)};
        #2;
        chk("R2", q_out, model[N-1]);
        chk("R5", q_out_n, ~model[N-1]);
        if (!clear) chk("R7 half holds on rise", q_half, prev);
        @(negedge clk);
        #2;
        chk("R6", q_half, model[N-1]);
        chk("R7 stages hold on fall", q_out, model[N-1]);
        chk("R9", clk_fwd, clk);
    endtask

    task automatic t_reset;
        clear = 1'b1;
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b1);
        chk("R1 q", q_out, 1'b0);
        chk("R1 half", q_half, 1'b0);
        clear = 1'b0;
        for (int i = 0; i < N; i++) tick(1'b1, 1'b0, 1'b0);
        chk("R1 reload", q_out, 1'b1);
        clear = 1'b1;
        tick(1'b1, 1'b0, 1'b1);
        tick(1'b1, 1'b0, 1'b1);
        chk("R1 midrun q", q_out, 1'b0);
        chk("R1 midrun half", q_half, 1'b0);
        clear = 1'b0;
    endtask

    task automatic t_latency;
        int count;
        bit seen;
        count = 0; seen = 1'b0;
        tick(1'b1, 1'b0, 1'b0);
        count = 1;
        while (!seen && count < 3 * N) begin
            if (q_out === 1'b1) seen = 1'b1;
            else begin tick(1'b0, 1'b0, 1'b1); count++; end
        end
        n_checks++;
        if (count != N) begin
            n_fail++;
            $display("FAIL R2 latency: actual %0d expected %0d", count, N);
        end
    endtask

    task automatic t_data_mode;
        for (int i = 0; i < N + 20; i++) begin
            logic b;
            b = ((i % 3) == 0) ^ ((i % 7) == 1);
            tick(b, 1'b0, ~b);
        end
        chk("R3 final", q_out, model[N-1]);
    endtask

    task automatic t_recirc_mode;
        for (int i = 0; i < N + 20; i++) begin
            logic b;
            b = ((i % 5) < 2);
            tick(~b, 1'b1, b);
        end
        chk("R4 final", q_out, model[N-1]);
    endtask

    task automatic t_loop;
        logic [N-1:0] snapshot;
        snapshot = model;
        for (int i = 0; i < 2 * N; i++) tick(1'b0, 1'b1, q_out);
        n_checks++;
        if (model !== snapshot) begin
            n_fail++;
            $display("FAIL R10 rotation: actual %h expected %h", model, snapshot);
        end
        for (int i = 0; i < N; i++) begin
            chk("R10", q_out, snapshot[N-1-i]);
            tick(1'b1, 1'b1, q_out);
        end
    endtask

    task automatic t_static;
        logic hq, hh;
        // park low (at falling edge + 2)
        hq = q_out; hh = q_half;
        clk_run = 1'b0;
        #(CLK_PERIOD * 50);
        chk("R8 low q", q_out, hq);
        chk("R8 low half", q_half, hh);
        chk("R9 low", clk_fwd, 1'b0);
        clk_run = 1'b1;
        tick(1'b1, 1'b0, 1'b0);
        // park high (at rising edge + 2)
        data_in = 1'b0; src_sel = 1'b0;
        @(posedge clk);
        model = {model[N-2:0], 1'b0};
        #2;
        clk_run = 1'b0;
        hq = q_out; hh = q_half;
        #(CLK_PERIOD * 50);
        chk("R8 high q", q_out, hq);
        chk("R8 high expected", q_out, model[N-1]);
        chk("R8 high half", q_half, hh);
        chk("R9 high", clk_fwd, 1'b1);
        clk_run = 1'b1;
        @(negedge clk);
        #2;
        chk("R8 resume half", q_half, model[N-1]);
        for (int i = 0; i < N; i++) tick(i[0], 1'b0, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_data_mode();
        t_recirc_mode();
        t_loop();
        t_static();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule